// File: doc/BRIEF.md
# Selectable Clock-Ratio Generator with Power-Down Freeze

This block derives a slower core timing signal from a master clock. A 2-bit ratio code picks one of four division factors: 1, 2, 4, or a top ratio that defaults to 6. The block drives two outputs. One is a registered divided-clock level. The other is a one-cycle tick that logic running on the master clock uses as a clock enable.

A new ratio code only takes effect at the end of the current output period, so no output pulse is ever cut short. A power-down input stops the generator while it is high: both outputs stay low and the counter is held at zero. When power-down is released, counting restarts from zero and the first tick comes one full divided period later.

The divided level is made by a register. It therefore cannot toggle at the master rate. In ÷1 it stays high and the tick is asserted in every cycle.

Top module: `clk_ratio_gen`

## Requirements
- R1: While reset is asserted (rst_n low), tick_o and clk_div_o are 0. The active ratio resets to ÷1 regardless of div_sel. After reset is released with power-down low, the first tick appears on the first clock edge. The code present at that edge then governs the next period.
- R2: Code 2'b00 selects ÷1: tick_o is 1 in every cycle and clk_div_o stays 1.
- R3: Code 2'b01 selects ÷2: tick_o comes every 2 cycles, and clk_div_o is high 1 cycle and low 1 cycle.
- R4: Code 2'b10 selects ÷4: tick_o comes every 4 cycles, and clk_div_o is high 2 cycles and low 2 cycles.
- R5: Code 2'b11 selects ÷TOP_RATIO (default 6): tick_o comes every 6 cycles, and clk_div_o is high 3 cycles and low 3 cycles.
- R6: A code change in the middle of a period does not shorten that period. The new ratio starts with the period that follows the next tick.
- R7: From the first clock edge at which pwr_down is 1, and for as long as it stays 1, tick_o and clk_div_o are 0.
- R8: The first tick after pwr_down falls appears exactly N edges later, where N is the ratio of the code present during power-down.
- R9: tick_o is 1 exactly in the cycles in which clk_div_o has just risen, or, in ÷1, in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_m | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_sel | input | 2 | Ratio code: 00 ÷1, 01 ÷2, 10 ÷4, 11 ÷TOP_RATIO |
| pwr_down | input | 1 | 1 stops the generator and clears its outputs |
| clk_div_o | output | 1 | Registered divided-clock level |
| tick_o | output | 1 | One-cycle strobe at each rising edge of clk_div_o |

## Verification
Both outputs are registers, so every result settles one edge after the state that causes it. The bench drives inputs on falling edges and samples on the following falling edges. After power-down is released, the first tick is due on sample N, where N is the ratio, and later ticks come every N samples. Power-down clears both outputs on sample 1. A mid-period code change shows up only after the tick that ends the current period, so the checks count samples from a known tick and never wait for an event of unknown timing.

// File: rtl/clk_ratio_gen.sv
module clk_ratio_gen #(
  parameter int TOP_RATIO = 6
) (
  input  logic       clk_m,
  input  logic       rst_n,
  input  logic [1:0] div_sel,
  input  logic       pwr_down,
  output logic       clk_div_o,
  output logic       tick_o
);
  localparam int CW = $clog2(TOP_RATIO > 4 ? TOP_RATIO : 4);

  logic [1:0]    cur_sel;
  logic [CW-1:0] cnt, last, half;
  logic          wrap;

  always_comb begin
    case (cur_sel)
      2'b00:   begin last = CW'(0);           half = CW'(0); end
      2'b01:   begin last = CW'(1);           half = CW'(1); end
      2'b10:   begin last = CW'(3);           half = CW'(2); end
      default: begin last = CW'(TOP_RATIO-1); half = CW'(TOP_RATIO/2); end
    endcase
  end

  assign wrap = (cnt == last);

  always_ff @(posedge clk_m or negedge rst_n) begin
    if (!rst_n) begin
      cur_sel   <= 2'b00;
      cnt       <= '0;
      clk_div_o <= 1'b0;
      tick_o    <= 1'b0;
    end else if (pwr_down) begin
      cur_sel   <= div_sel;
      cnt       <= '0;
      clk_div_o <= 1'b0;
      tick_o    <= 1'b0;
    end else begin
      tick_o <= wrap;
      if (wrap) begin
        cnt       <= '0;
        cur_sel   <= div_sel;
        clk_div_o <= 1'b1;
      end else begin
        cnt <= cnt + CW'(1);
        if ((cnt + CW'(1)) == half) clk_div_o <= 1'b0;
      end
    end
  end

  initial begin
    p_even_top_ratio: assert (TOP_RATIO >= 4 && TOP_RATIO % 2 == 0)
      else $error("TOP_RATIO must be even and at least 4");
  end

  p_pd_quiet_r7: assert property (@(posedge clk_m) disable iff (!rst_n)
    pwr_down |=> (!tick_o && !clk_div_o));

  p_tick_on_rise_r9: assert property (@(posedge clk_m) disable iff (!rst_n)
    $rose(clk_div_o) |-> tick_o);

  p_tick_high_r9: assert property (@(posedge clk_m) disable iff (!rst_n)
    tick_o |-> clk_div_o);

  p_ratio_at_end_r6: assert property (@(posedge clk_m) disable iff (!rst_n)
    !$stable(cur_sel) |-> (tick_o || $past(pwr_down)));

  p_cnt_range_r5: assert property (@(posedge clk_m) disable iff (!rst_n)
    cnt <= last);
endmodule

// File: tb/test_clk_ratio_gen.sv
module test_clk_ratio_gen;
  logic clk_m = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] div_sel = 2'b11;
  logic pwr_down = 1'b0;
  logic clk_div_o, tick_o;
  int errors = 0;
  int checks = 0;

  clk_ratio_gen i_clk_ratio_gen (
    .clk_m(clk_m), .rst_n(rst_n), .div_sel(div_sel), .pwr_down(pwr_down),
    .clk_div_o(clk_div_o), .tick_o(tick_o)
  );

  always #2 clk_m = ~clk_m;

  // {code, period, high cycles}
  localparam int VEC [4][3] = '{'{0, 1, 1}, '{1, 2, 1}, '{2, 4, 2}, '{3, 6, 3}};
  string tag_of [4] = '{"R2", "R3", "R4", "R5"};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_tick(output int k, input int limit);
    k = 0;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk_m);
      if (tick_o) begin k = i; break; end
    end
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int k, tk, hi, bad, prev;
    // R1: reset state, default ratio ÷1 even with code 11 applied
    repeat (3) @(negedge clk_m);
    chk(!tick_o && !clk_div_o, "R1 outputs in reset", {tick_o, clk_div_o}, 0);
    rst_n = 1'b1;
    wait_tick(k, 20);
    chk(k == 1, "R1 first tick at default ratio", k, 1);
    wait_tick(k, 20);
    chk(k == 6, "R1 code applied after first period", k, 6);

    // R2..R5 and R8: table of codes
    for (int v = 0; v < 4; v++) begin
      @(negedge clk_m);
      pwr_down = 1'b1; div_sel = 2'(VEC[v][0]);
      @(negedge clk_m);
      pwr_down = 1'b0;
      wait_tick(k, 20);
      chk(k == VEC[v][1], "R8 first tick after power-down exit", k, VEC[v][1]);
      tk = 0; hi = 0; bad = 0; prev = 1;
      for (int i = 0; i < 2 * VEC[v][1]; i++) begin
        @(negedge clk_m);
        tk += int'(tick_o); hi += int'(clk_div_o);
        if (tick_o != (clk_div_o && (!prev || VEC[v][1] == 1))) bad++;
        prev = int'(clk_div_o);
      end
      chk(tk == 2, {tag_of[v], " tick count over two periods"}, tk, 2);
      chk(hi == 2 * VEC[v][2], {tag_of[v], " high cycles over two periods"}, hi, 2 * VEC[v][2]);
      chk(bad == 0, "R9 tick matches rising edge", bad, 0);
    end

    // R6: mid-period change keeps current period
    @(negedge clk_m);
    pwr_down = 1'b1; div_sel = 2'b11;
    @(negedge clk_m);
    pwr_down = 1'b0;
    wait_tick(k, 20);
    repeat (2) @(negedge clk_m);
    div_sel = 2'b01;
    wait_tick(k, 20);
    chk(k == 4, "R6 current period not shortened", k + 2, 6);
    wait_tick(k, 20);
    chk(k == 2, "R6 new ratio after period end", k, 2);

    // R7: power-down freezes outputs
    @(negedge clk_m);
    pwr_down = 1'b1;
    bad = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk_m);
      if (tick_o || clk_div_o) bad++;
    end
    chk(bad == 0, "R7 outputs low in power-down", bad, 0);
    div_sel = 2'b10;
    @(negedge clk_m);
    pwr_down = 1'b0;
    wait_tick(k, 20);
    chk(k == 4, "R8 restart after power-down at ÷4", k, 4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule